// File: doc/BRIEF.md
# Drawing Engine Register Queue Front End

This block sits between a 16-bit host register write port and a 2D drawing engine. Each host write names a target register through a small select code and carries a 16-bit value. Writes enter an eight-entry first-in first-out queue. The queue drains in order into a set of parameter registers that the engine reads: the start position, the major-axis count, the colour, the clip edges, the minor-axis count and the pixel control.

One select code is a multiplexed port. The top four bits of its value choose a sub-register, and the low twelve bits are stored there. Another select code is the command register. A command entry stays at the head of the queue until the engine is idle. When it leaves, it raises a one-cycle launch strobe with the decoded operation type.

The host reads a status word in place of the command register. The status word holds three things: a thermometer of free queue slots, a busy flag, and an all-empty flag. A write that arrives while the queue is full is lost, and it sets a sticky overflow flag.

Top module: `draw_cmd_frontend`

## Requirements
- R1: Accepted writes take effect in the order they were written. A write sampled at clock edge k, arriving at an empty queue with no command ahead of it, is visible on its output at edge k+1. The queue holds at most 8 entries.
- R2: Select codes are mapped as follows: 0 is X start, 1 is Y start, 2 is major-axis count, 3 is foreground colour, 4 is the multiplexed port and 5 is the command register. Each of codes 0 to 3 stores all 16 bits. Codes 6 and 7 change no output.
- R3: A write while the queue holds 8 entries is discarded. It sets overflow_o, which stays high until reset.
- R4: For N from 1 to 8, status bit (8-N) is 1 exactly when at least N slots are free. Bit 7 therefore means at least one slot is free, and bit 0 means all eight are free.
- R5: Status bit 9 is 1 whenever any of these holds: engine_busy_i is high, a command entry is waiting in the queue, or the launch strobe is high.
- R6: Status bit 10 is 1 exactly when the queue is empty. Status bits 8 and 15:11 read 0.
- R7: On the multiplexed port, value bits 15:12 select a sub-register and bits 11:0 are stored in it. The selections are: 0x0 minor count, 0x1 clip top, 0x2 clip left, 0x3 clip bottom, 0x4 clip right and 0xA pixel control. Any other index changes nothing.
- R8: A command entry raises cmd_valid_o for one cycle, and cmd_word_o holds the whole word. cmd_type_o is bits 15:13 of the word: 001 is line, 010 is rectangle and 110 is screen-to-screen copy. cmd_draw_o is bit 4, where 1 means draw and 0 means move.
- R9: A command at the head leaves only in a cycle where engine_busy_i is low and no launch strobe was raised in the cycle before. Entries behind it wait.
- R10: After reset all parameter outputs are 0, no strobe is raised, overflow_o is 0 and the status word is 0x04FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write request |
| wr_sel_i | input | 3 | Target register select code |
| wr_data_i | input | 16 | Write value |
| engine_busy_i | input | 1 | Engine is executing an operation |
| status_o | output | 16 | Status word read at the command address |
| overflow_o | output | 1 | Sticky flag for a write lost to a full queue |
| cur_x_o | output | 16 | X start position |
| cur_y_o | output | 16 | Y start position |
| maj_cnt_o | output | 16 | Major-axis count |
| fg_color_o | output | 16 | Foreground colour |
| minor_cnt_o | output | 12 | Minor-axis count |
| clip_top_o | output | 12 | Clip top edge |
| clip_left_o | output | 12 | Clip left edge |
| clip_bot_o | output | 12 | Clip bottom edge |
| clip_right_o | output | 12 | Clip right edge |
| pix_ctl_o | output | 12 | Pixel control |
| cmd_valid_o | output | 1 | One-cycle launch strobe |
| cmd_type_o | output | 3 | Operation type of the last command |
| cmd_draw_o | output | 1 | Draw (1) or move (0) bit of the last command |
| cmd_word_o | output | 16 | Last command word |

## Verification
The bench holds the engine busy behind a pending command so that the queue fills completely. It then writes once more.

Several mistakes show up in this test. An off-by-one full check would either lose the eighth write or overwrite the head. It would also shift the thermometer by one bit. A queue that let parameter writes pass a stalled command would update the clip or colour outputs too early.

Back-to-back commands test whether a design launches a second command before the engine has reported busy. Sub-register indices outside the defined set test that a loose decoder does not corrupt one of the clip registers.

// File: rtl/draw_fe_pkg.sv
package draw_fe_pkg;
  localparam int DATA_W = 16;
  localparam int SEL_W  = 3;
  localparam int SUB_W  = 12;

  localparam logic [SEL_W-1:0] SEL_X   = 3'd0;
  localparam logic [SEL_W-1:0] SEL_Y   = 3'd1;
  localparam logic [SEL_W-1:0] SEL_MAJ = 3'd2;
  localparam logic [SEL_W-1:0] SEL_FG  = 3'd3;
  localparam logic [SEL_W-1:0] SEL_MUX = 3'd4;
  localparam logic [SEL_W-1:0] SEL_CMD = 3'd5;

  localparam logic [3:0] SUB_MINOR = 4'h0;
  localparam logic [3:0] SUB_TOP   = 4'h1;
  localparam logic [3:0] SUB_LEFT  = 4'h2;
  localparam logic [3:0] SUB_BOT   = 4'h3;
  localparam logic [3:0] SUB_RIGHT = 4'h4;
  localparam logic [3:0] SUB_PIX   = 4'hA;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] data;
  } fe_entry_t;
endpackage

// File: rtl/draw_fe_fifo.sv
module draw_fe_fifo
  import draw_fe_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  fe_entry_t        entry_i,
  input  logic             pop_i,
  output fe_entry_t        head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             push_ok_o,
  output logic             ovf_o
);
  fe_entry_t        mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic             full, do_pop;

  assign full      = (count_o == CNT_W'(DEPTH));
  assign push_ok_o = push_i && !full;
  assign do_pop    = pop_i && (count_o != '0);
  assign head_o    = mem[rptr];

  always_ff @(posedge clk_i) begin
    if (push_ok_o) mem[wptr] <= entry_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr    <= '0;
      rptr    <= '0;
      count_o <= '0;
      ovf_o   <= 1'b0;
    end else begin
      if (push_ok_o) wptr <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_pop)    rptr <= (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({push_ok_o, do_pop})
        2'b10:   count_o <= count_o + 1'b1;
        2'b01:   count_o <= count_o - 1'b1;
        default: ;
      endcase
      if (push_i && full) ovf_o <= 1'b1;
    end
  end

  assert_full_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !pop_i) |=> $stable(count_o));
  assert_ovf_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  assert_pop_count_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_pop && !push_i) |=> (count_o == $past(count_o) - 1'b1));
endmodule

// File: rtl/draw_fe_regs.sv
module draw_fe_regs
  import draw_fe_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              apply_i,
  input  fe_entry_t         entry_i,
  output logic [DATA_W-1:0] cur_x_o,
  output logic [DATA_W-1:0] cur_y_o,
  output logic [DATA_W-1:0] maj_cnt_o,
  output logic [DATA_W-1:0] fg_color_o,
  output logic [SUB_W-1:0]  minor_cnt_o,
  output logic [SUB_W-1:0]  clip_top_o,
  output logic [SUB_W-1:0]  clip_left_o,
  output logic [SUB_W-1:0]  clip_bot_o,
  output logic [SUB_W-1:0]  clip_right_o,
  output logic [SUB_W-1:0]  pix_ctl_o,
  output logic              cmd_valid_o,
  output logic [DATA_W-1:0] cmd_word_o
);
  logic [3:0]       sub_idx;
  logic [SUB_W-1:0] sub_val;
  assign sub_idx = entry_i.data[DATA_W-1 -: 4];
  assign sub_val = entry_i.data[SUB_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_x_o      <= '0;
      cur_y_o      <= '0;
      maj_cnt_o    <= '0;
      fg_color_o   <= '0;
      minor_cnt_o  <= '0;
      clip_top_o   <= '0;
      clip_left_o  <= '0;
      clip_bot_o   <= '0;
      clip_right_o <= '0;
      pix_ctl_o    <= '0;
      cmd_valid_o  <= 1'b0;
      cmd_word_o   <= '0;
    end else begin
      cmd_valid_o <= apply_i && (entry_i.sel == SEL_CMD);
      if (apply_i) begin
        case (entry_i.sel)
          SEL_X:   cur_x_o    <= entry_i.data;
          SEL_Y:   cur_y_o    <= entry_i.data;
          SEL_MAJ: maj_cnt_o  <= entry_i.data;
          SEL_FG:  fg_color_o <= entry_i.data;
          SEL_CMD: cmd_word_o <= entry_i.data;
          SEL_MUX: begin
            case (sub_idx)
              SUB_MINOR: minor_cnt_o  <= sub_val;
              SUB_TOP:   clip_top_o   <= sub_val;
              SUB_LEFT:  clip_left_o  <= sub_val;
              SUB_BOT:   clip_bot_o   <= sub_val;
              SUB_RIGHT: clip_right_o <= sub_val;
              SUB_PIX:   pix_ctl_o    <= sub_val;
              default: ;
            endcase
          end
          default: ;
        endcase
      end
    end
  end

  assert_strobe_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);
endmodule

// File: rtl/draw_fe_status.sv
module draw_fe_status #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic             busy_i,
  output logic [15:0]      status_o
);
  localparam int THERM_W = 8;
  logic [CNT_W-1:0]   free_slots;
  logic [THERM_W-1:0] therm;

  assign free_slots = CNT_W'(DEPTH) - count_i;

  for (genvar k = 0; k < THERM_W; k++) begin : g_therm
    assign therm[k] = (int'(free_slots) >= (THERM_W - k));
  end

  assign status_o = {5'b0, (count_i == '0), busy_i, 1'b0, therm};

  assert_empty_all_free_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[10] |-> (status_o[7:0] == 8'hFF));
endmodule

// File: rtl/draw_cmd_frontend.sv
module draw_cmd_frontend
  import draw_fe_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              engine_busy_i,
  output logic [15:0]       status_o,
  output logic              overflow_o,
  output logic [DATA_W-1:0] cur_x_o,
  output logic [DATA_W-1:0] cur_y_o,
  output logic [DATA_W-1:0] maj_cnt_o,
  output logic [DATA_W-1:0] fg_color_o,
  output logic [SUB_W-1:0]  minor_cnt_o,
  output logic [SUB_W-1:0]  clip_top_o,
  output logic [SUB_W-1:0]  clip_left_o,
  output logic [SUB_W-1:0]  clip_bot_o,
  output logic [SUB_W-1:0]  clip_right_o,
  output logic [SUB_W-1:0]  pix_ctl_o,
  output logic              cmd_valid_o,
  output logic [2:0]        cmd_type_o,
  output logic              cmd_draw_o,
  output logic [DATA_W-1:0] cmd_word_o
);
  fe_entry_t        wr_entry, head;
  logic [CNT_W-1:0] count, cmd_cnt;
  logic             push_ok, head_cmd, pop, pop_cmd, busy_stat;

  assign wr_entry = '{sel: wr_sel_i, data: wr_data_i};
  assign head_cmd = (head.sel == SEL_CMD);
  // command waits for idle engine and for the previous strobe to be seen
  assign pop      = (count != '0) && (!head_cmd || (!engine_busy_i && !cmd_valid_o));
  assign pop_cmd  = pop && head_cmd;

  draw_fe_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(wr_en_i), .entry_i(wr_entry), .pop_i(pop),
    .head_o(head), .count_o(count), .push_ok_o(push_ok), .ovf_o(overflow_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_cnt <= '0;
    else case ({push_ok && (wr_sel_i == SEL_CMD), pop_cmd})
      2'b10:   cmd_cnt <= cmd_cnt + 1'b1;
      2'b01:   cmd_cnt <= cmd_cnt - 1'b1;
      default: ;
    endcase
  end

  draw_fe_regs u_regs (
    .clk_i, .rst_ni, .apply_i(pop), .entry_i(head),
    .cur_x_o, .cur_y_o, .maj_cnt_o, .fg_color_o, .minor_cnt_o,
    .clip_top_o, .clip_left_o, .clip_bot_o, .clip_right_o, .pix_ctl_o,
    .cmd_valid_o, .cmd_word_o
  );

  assign cmd_type_o = cmd_word_o[15:13];
  assign cmd_draw_o = cmd_word_o[4];
  assign busy_stat  = engine_busy_i || cmd_valid_o || (cmd_cnt != '0);

  draw_fe_status #(.DEPTH(DEPTH)) u_status (
    .clk_i, .rst_ni, .count_i(count), .busy_i(busy_stat), .status_o
  );

  assert_launch_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_valid_o) |-> !$past(engine_busy_i));
  assert_strobe_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> status_o[9]);
  assert_full_no_free_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count == CNT_W'(DEPTH)) |-> (status_o[7:0] == 8'h00));
endmodule

// File: tb/sim_draw_cmd_frontend.sv
`timescale 1ns/1ps
module sim_draw_cmd_frontend;
  logic clk = 0, rst_ni = 0;
  logic wr_en_i = 0;
  logic [2:0] wr_sel_i = 0;
  logic [15:0] wr_data_i = 0;
  logic engine_busy_i = 0;
  logic [15:0] status_o, cur_x_o, cur_y_o, maj_cnt_o, fg_color_o, cmd_word_o;
  logic [11:0] minor_cnt_o, clip_top_o, clip_left_o, clip_bot_o, clip_right_o, pix_ctl_o;
  logic overflow_o, cmd_valid_o, cmd_draw_o;
  logic [2:0] cmd_type_o;

  always #4 clk = ~clk;

  draw_cmd_frontend u0 (.clk_i(clk), .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .engine_busy_i, .status_o, .overflow_o, .cur_x_o, .cur_y_o, .maj_cnt_o,
    .fg_color_o, .minor_cnt_o, .clip_top_o, .clip_left_o, .clip_bot_o,
    .clip_right_o, .pix_ctl_o, .cmd_valid_o, .cmd_type_o, .cmd_draw_o, .cmd_word_o);

  int tests = 0, fails = 0, cyc = 0;
  // reference model state
  logic [18:0] q[$];
  logic [15:0] m_x, m_y, m_maj, m_fg, m_cmd;
  logic [11:0] m_min, m_top, m_left, m_bot, m_right, m_pix;
  logic m_cv, m_ovf, hold;
  int eng_cnt;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  task automatic m_reset();
    q.delete();
    {m_x, m_y, m_maj, m_fg, m_cmd} = '0;
    {m_min, m_top, m_left, m_bot, m_right, m_pix} = '0;
    m_cv = 0; m_ovf = 0;
  endtask

  initial m_reset();

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) m_reset();
    else begin
      int sz;
      logic [18:0] h;
      bit popped;
      sz = q.size();
      popped = 0;
      m_cv = 0;
      if (sz > 0) begin
        h = q[0];
        if (h[18:16] != 3'd5 || (!engine_busy_i && !m_cv_prev)) begin
          popped = 1;
          void'(q.pop_front());
          case (h[18:16])
            3'd0: m_x = h[15:0];
            3'd1: m_y = h[15:0];
            3'd2: m_maj = h[15:0];
            3'd3: m_fg = h[15:0];
            3'd5: begin m_cmd = h[15:0]; m_cv = 1; end
            3'd4: case (h[15:12])
              4'h0: m_min = h[11:0];
              4'h1: m_top = h[11:0];
              4'h2: m_left = h[11:0];
              4'h3: m_bot = h[11:0];
              4'h4: m_right = h[11:0];
              4'hA: m_pix = h[11:0];
              default: ;
            endcase
            default: ;
          endcase
        end
      end
      if (wr_en_i) begin
        if (sz == 8) m_ovf = 1;
        else q.push_back({wr_sel_i, wr_data_i});
      end
      m_cv_prev = m_cv;
    end
  end
  logic m_cv_prev = 0;
  always @(negedge rst_ni) m_cv_prev = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_ni) begin
      bit any_cmd, busy;
      logic [15:0] st;
      int fr;
      any_cmd = 0;
      foreach (q[i]) if (q[i][18:16] == 3'd5) any_cmd = 1;
      busy = engine_busy_i || m_cv || any_cmd;
      fr = 8 - q.size();
      st = '0;
      for (int k = 0; k < 8; k++) st[k] = (fr >= 8 - k);
      st[9] = busy;
      st[10] = (q.size() == 0);
      chk(status_o[7:0] == st[7:0], "R4 thermometer", status_o, st);
      chk(status_o[9] == st[9], "R5 busy bit", status_o, st);
      chk(status_o[10] == st[10] && status_o[15:11] == 0 && !status_o[8], "R6 empty/zero bits", status_o, st);
      chk(overflow_o == m_ovf, "R3 overflow", overflow_o, m_ovf);
      chk({cur_x_o, cur_y_o} == {m_x, m_y}, "R1 R2 position", {cur_x_o, cur_y_o}, {m_x, m_y});
      chk({maj_cnt_o, fg_color_o} == {m_maj, m_fg}, "R2 count/colour", {maj_cnt_o, fg_color_o}, {m_maj, m_fg});
      chk({minor_cnt_o, clip_top_o} == {m_min, m_top}, "R7 minor/top", {minor_cnt_o, clip_top_o}, {m_min, m_top});
      chk({clip_left_o, clip_bot_o} == {m_left, m_bot}, "R7 left/bottom", {clip_left_o, clip_bot_o}, {m_left, m_bot});
      chk({clip_right_o, pix_ctl_o} == {m_right, m_pix}, "R7 right/pixctl", {clip_right_o, pix_ctl_o}, {m_right, m_pix});
      chk(cmd_valid_o == m_cv, "R9 launch timing", cmd_valid_o, m_cv);
      chk(cmd_word_o == m_cmd && cmd_type_o == m_cmd[15:13] && cmd_draw_o == m_cmd[4],
          "R8 command fields", {cmd_type_o, cmd_draw_o, cmd_word_o}, {m_cmd[15:13], m_cmd[4], m_cmd});
      if (m_cv) eng_cnt = 3;
      else if (eng_cnt > 0) eng_cnt--;
      engine_busy_i = hold || (eng_cnt > 0);
    end
    if (cyc > 5000) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk);
    wr_en_i = 1; wr_sel_i = s; wr_data_i = d;
  endtask
  task automatic idle(input int n);
    @(negedge clk);
    wr_en_i = 0;
    repeat (n - 1) @(negedge clk);
  endtask

  initial begin
    hold = 0; eng_cnt = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    #1;
    // R10 reset state
    chk(status_o == 16'h04FF && !cmd_valid_o && !overflow_o && cur_x_o == 0 && clip_right_o == 0,
        "R10 reset state", status_o, 16'h04FF);
    // R2 plain registers, codes 6/7 ignored
    wr(0, 16'h1234); wr(1, 16'hABCD); wr(2, 16'h00FF); wr(3, 16'hF00D);
    wr(6, 16'hFFFF); wr(7, 16'h5555);
    idle(4);
    // R7 sub-registers and unused indices
    wr(4, 16'h0123); wr(4, 16'h1011); wr(4, 16'h2022); wr(4, 16'h3033);
    wr(4, 16'h4044); wr(4, 16'hA0AA); wr(4, 16'h5FFF); wr(4, 16'hFEEE); wr(4, 16'hB777);
    idle(4);
    // R8 commands: line draw, rect move, copy draw back to back
    wr(5, 16'h2014); wr(5, 16'h4000); wr(5, 16'hC0B0);
    idle(20);
    // R3 R4 R9: hold engine busy, fill queue, overflow
    hold = 1;
    wr(5, 16'h4010);
    for (int i = 0; i < 9; i++) wr(4, 16'h1000 + 16'(i));
    wr(0, 16'h7777);
    idle(4);
    hold = 0;
    idle(20);
    // R1 mixed stream
    for (int i = 0; i < 12; i++) wr(3'(i % 6), 16'(i * 16'h0111));
    idle(30);
    // reset clears overflow (R3, R10)
    rst_ni = 0;
    idle(2);
    rst_ni = 1;
    idle(2);
    #1;
    chk(!overflow_o && status_o == 16'h04FF, "R3 R10 reset clears", {overflow_o, status_o}, 17'h004FF);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule